// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block takes the addressing part of an interrupt message and works out which agents, out of a parameterised set, are its targets. The addressing part is a 32-bit destination field, a physical/logical mode bit and a two-bit shorthand code. Each agent supplies a live description of itself on every cycle:
- whether it is present;
- whether it runs in extended (32-bit identifier) mode;
- its physical identifier;
- its logical destination register;
- in non-extended mode, whether it uses the flat or the cluster logical model.

The block answers with a bitmask holding one bit per agent. For requests flagged as lowest-priority delivery, it also names a single chosen agent: the lowest-indexed agent in that mask. It does not arbitrate by priority. All matching is combinational. The mask, the pick and a valid pulse are registered together, so the answer appears one clock after the request. A system uses it between the message source and the per-agent delivery logic. It does not deliver anything itself.

Top module: `dest_resolver`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released, `res_valid`, `res_mask` and `res_pick_valid` are all zero.
- R2: A request sampled with `req_valid` high at a rising clock edge produces `res_valid` high for exactly the following cycle. Back-to-back requests give back-to-back results in request order. `res_valid` is low after any edge at which `req_valid` was low.
- R3: With shorthand 0 and `req_logical`=0 (physical mode), an extended-mode agent matches when its full 32-bit identifier equals the destination. A non-extended agent matches when the low 8 bits of its identifier equal destination bits 7:0.
- R4: In physical mode, a destination exactly equal to 0x000000FF also selects every non-extended agent. Extended agents still need a full identifier match.
- R5: In physical mode, a destination of 0xFFFFFFFF selects every agent.
- R6: In logical mode, a destination of 0xFFFFFFFF selects every extended agent. Non-extended agents are judged by their normal logical rule, using destination bits 7:0 (0xFF).
- R7: In logical mode, an extended agent matches when destination bits 31:16 equal its logical register bits 31:16, and bits 15:0 of the two share at least one set bit.
- R8: In logical mode, a non-extended agent in the flat model (`agent_cluster`=0) matches when destination bits 7:0 and its logical register bits 7:0 share a set bit.
- R9: In logical mode, a non-extended agent in the cluster model (`agent_cluster`=1) has two conditions to meet. Destination bits 7:4 must be 0xF or equal its logical register bits 7:4. Bits 3:0 of the two must also share a set bit.
- R10: For shorthand 1 only agent `req_sender` is selected. Shorthand 2 selects all agents. Shorthand 3 selects all agents except `req_sender`. Under any non-zero shorthand, destination and mode have no effect.
- R11: An agent whose `agent_present` bit is 0 is never set in `res_mask`. This holds under broadcasts and shorthands too.
- R12: `res_pick_valid` is 1 only for a request with `req_lowpri`=1 whose resolved mask is non-empty. `res_pick_idx` is then the lowest set index of `res_mask`. An empty mask gives `res_pick_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| agent_present | input | N_AGENTS | Per-agent presence |
| agent_ext | input | N_AGENTS | Per-agent extended-mode flag |
| agent_phys_id | input | 32*N_AGENTS | Physical identifiers, agent i in bits [32i+31:32i] |
| agent_logid | input | 32*N_AGENTS | Logical destination registers, same packing |
| agent_cluster | input | N_AGENTS | Non-extended logical model: 1 cluster, 0 flat |
| req_valid | input | 1 | Request strobe |
| req_dest | input | 32 | Destination field |
| req_logical | input | 1 | 1 logical, 0 physical |
| req_shorthand | input | 2 | 0 field, 1 self, 2 all, 3 all but self |
| req_sender | input | IDX_W | Index of the sending agent |
| req_lowpri | input | 1 | Lowest-priority delivery request |
| res_valid | output | 1 | Result strobe, one cycle after request |
| res_mask | output | N_AGENTS | Resolved target bitmask |
| res_pick_valid | output | 1 | Single target reported |
| res_pick_idx | output | IDX_W | Selected target index |

## Verification
Presence masking and lowest-priority selection act on the same mask in the same cycle. If the pick were taken before absent agents are cleared, it would name an agent that is not there. The bench provokes this by marking agent 0 absent and then sending lowest-priority requests under the all-agents shorthand and under a physical broadcast. The pick must then be agent 1. The bench compares the expected pick index, which it computes from its own model of the mask, against both `res_pick_idx` and the returned mask.

// File: rtl/dest_resolver_pkg.sv
package dest_resolver_pkg;
  localparam int DEST_W = 32;
  localparam int LOW_W  = 8;
  localparam int HALF_W = DEST_W / 2;
  localparam int NIB_W  = LOW_W / 2;

  typedef enum logic [1:0] {
    SH_FIELD  = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  // physical identifier comparison, width depends on agent mode
  function automatic logic phys_hit(input logic ext,
                                    input logic [DEST_W-1:0] id,
                                    input logic [DEST_W-1:0] dest);
    if (ext) return id == dest;
    return id[LOW_W-1:0] == dest[LOW_W-1:0];
  endfunction

  // logical rule for one agent (extended, flat or cluster)
  function automatic logic logical_hit(input logic ext,
                                       input logic cluster_model,
                                       input logic [DEST_W-1:0] ldr,
                                       input logic [DEST_W-1:0] dest);
    logic grp_ok;
    if (ext) begin
      grp_ok = dest[DEST_W-1:HALF_W] == ldr[DEST_W-1:HALF_W];
      return grp_ok && ((dest[HALF_W-1:0] & ldr[HALF_W-1:0]) != '0);
    end
    if (!cluster_model)
      return (dest[LOW_W-1:0] & ldr[LOW_W-1:0]) != '0;
    grp_ok = (dest[LOW_W-1:NIB_W] == {NIB_W{1'b1}}) ||
             (dest[LOW_W-1:NIB_W] == ldr[LOW_W-1:NIB_W]);
    return grp_ok && ((dest[NIB_W-1:0] & ldr[NIB_W-1:0]) != '0);
  endfunction

  function automatic logic is_wide_bcast(input logic [DEST_W-1:0] dest);
    return dest == {DEST_W{1'b1}};
  endfunction

  function automatic logic is_narrow_bcast(input logic [DEST_W-1:0] dest);
    return dest == DEST_W'({LOW_W{1'b1}});
  endfunction
endpackage

// File: rtl/agent_match.sv
module agent_match
  import dest_resolver_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int MY_IDX = 0
) (
  input  logic              present,
  input  logic              ext,
  input  logic [DEST_W-1:0] phys_id,
  input  logic [DEST_W-1:0] logid,
  input  logic              cluster_model,
  input  logic [DEST_W-1:0] dest,
  input  logic              logical,
  input  logic [1:0]        shorthand,
  input  logic [IDX_W-1:0]  sender,
  output logic              hit
);
  logic dest_hit;
  logic is_me;
  logic sel;

  assign is_me = sender == IDX_W'(MY_IDX);

  always_comb begin
    if (logical)
      dest_hit = logical_hit(ext, cluster_model, logid, dest) ||
                 (ext && is_wide_bcast(dest));
    else
      dest_hit = is_wide_bcast(dest) || phys_hit(ext, phys_id, dest) ||
                 (!ext && is_narrow_bcast(dest));
  end

  always_comb begin
    case (shorthand_e'(shorthand))
      SH_SELF:   sel = is_me;
      SH_ALL:    sel = 1'b1;
      SH_OTHERS: sel = !is_me;
      default:   sel = dest_hit;
    endcase
  end

  assign hit = sel && present;
endmodule

// File: rtl/lowest_pick.sv
module lowest_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     mask,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/dest_resolver.sv
module dest_resolver
  import dest_resolver_pkg::*;
#(
  parameter int N_AGENTS = 8,
  localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_AGENTS-1:0]          agent_present,
  input  logic [N_AGENTS-1:0]          agent_ext,
  input  logic [DEST_W*N_AGENTS-1:0]   agent_phys_id,
  input  logic [DEST_W*N_AGENTS-1:0]   agent_logid,
  input  logic [N_AGENTS-1:0]          agent_cluster,
  input  logic                         req_valid,
  input  logic [DEST_W-1:0]            req_dest,
  input  logic                         req_logical,
  input  logic [1:0]                   req_shorthand,
  input  logic [IDX_W-1:0]             req_sender,
  input  logic                         req_lowpri,
  output logic                         res_valid,
  output logic [N_AGENTS-1:0]          res_mask,
  output logic                         res_pick_valid,
  output logic [IDX_W-1:0]             res_pick_idx
);
  logic [N_AGENTS-1:0] next_mask;
  logic                next_found;
  logic [IDX_W-1:0]    next_idx;
  logic [N_AGENTS-1:0] pick_below;

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
    agent_match #(.IDX_W(IDX_W), .MY_IDX(g)) u_match (
      .present       (agent_present[g]),
      .ext           (agent_ext[g]),
      .phys_id       (agent_phys_id[g*DEST_W +: DEST_W]),
      .logid         (agent_logid[g*DEST_W +: DEST_W]),
      .cluster_model (agent_cluster[g]),
      .dest          (req_dest),
      .logical       (req_logical),
      .shorthand     (req_shorthand),
      .sender        (req_sender),
      .hit           (next_mask[g])
    );
  end

  lowest_pick #(.N(N_AGENTS), .IDX_W(IDX_W)) u_pick (
    .mask  (next_mask),
    .found (next_found),
    .idx   (next_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid      <= 1'b0;
      res_mask       <= '0;
      res_pick_valid <= 1'b0;
      res_pick_idx   <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_mask       <= next_mask;
        res_pick_valid <= req_lowpri && next_found;
        res_pick_idx   <= next_idx;
      end
    end
  end

  // agents below the reported pick, for the ordering check
  always_comb begin
    for (int i = 0; i < N_AGENTS; i++)
      pick_below[i] = IDX_W'(i) < res_pick_idx;
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);
  assert_absent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_mask & ~$past(agent_present)) == '0));
  assert_self_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(req_shorthand) == 2'd1) |-> ($countones(res_mask) <= 1));
  assert_pick_lowest_R12: assert property (@(posedge clk) disable iff (!rst_n)
    res_pick_valid |-> (res_mask[res_pick_idx] && ((res_mask & pick_below) == '0)));
  assert_pick_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_mask == '0) |-> !res_pick_valid);
  assert_pick_lowpri_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_pick_valid) |-> $past(req_lowpri));
endmodule

// File: tb/tb_dest_resolver.sv
`timescale 1ns/1ps
module tb_dest_resolver;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          pres [N];
  logic          ext  [N];
  logic [31:0]   pid  [N];
  logic [31:0]   lid  [N];
  logic          clm  [N];

  logic [N-1:0]    agent_present, agent_ext, agent_cluster;
  logic [32*N-1:0] agent_phys_id, agent_logid;
  logic            req_valid = 1'b0;
  logic [31:0]     req_dest = '0;
  logic            req_logical = 1'b0;
  logic [1:0]      req_shorthand = '0;
  logic [IW-1:0]   req_sender = '0;
  logic            req_lowpri = 1'b0;
  logic            res_valid, res_pick_valid;
  logic [N-1:0]    res_mask;
  logic [IW-1:0]   res_pick_idx;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      agent_present[i] = pres[i];
      agent_ext[i]     = ext[i];
      agent_cluster[i] = clm[i];
      agent_phys_id[i*32 +: 32] = pid[i];
      agent_logid[i*32 +: 32]   = lid[i];
    end
  end

  dest_resolver #(.N_AGENTS(N)) dut (
    .clk(clk), .rst_n(rst_n),
    .agent_present(agent_present), .agent_ext(agent_ext),
    .agent_phys_id(agent_phys_id), .agent_logid(agent_logid),
    .agent_cluster(agent_cluster),
    .req_valid(req_valid), .req_dest(req_dest), .req_logical(req_logical),
    .req_shorthand(req_shorthand), .req_sender(req_sender),
    .req_lowpri(req_lowpri),
    .res_valid(res_valid), .res_mask(res_mask),
    .res_pick_valid(res_pick_valid), .res_pick_idx(res_pick_idx)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  bit monitor_on = 0;

  logic [N-1:0]  q_mask [$];
  logic          q_pv   [$];
  logic [IW-1:0] q_idx  [$];
  string         q_tag  [$];

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // independent model of the requirements
  function automatic logic [N-1:0] model(input logic [31:0] d, input logic lg,
                                         input logic [1:0] sh, input int snd);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) begin
      logic s;
      if (sh == 2'd1)      s = (i == snd);
      else if (sh == 2'd2) s = 1'b1;
      else if (sh == 2'd3) s = (i != snd);
      else if (!lg) begin
        if (d == 32'hFFFF_FFFF) s = 1'b1;
        else if (ext[i])        s = (pid[i] == d);
        else                    s = (d == 32'h0000_00FF) || (pid[i][7:0] == d[7:0]);
      end else begin
        if (ext[i])
          s = (d == 32'hFFFF_FFFF) ||
              ((d[31:16] == lid[i][31:16]) && ((d[15:0] & lid[i][15:0]) != 16'h0));
        else if (clm[i])
          s = ((d[7:4] == 4'hF) || (d[7:4] == lid[i][7:4])) &&
              ((d[3:0] & lid[i][3:0]) != 4'h0);
        else
          s = (d[7:0] & lid[i][7:0]) != 8'h0;
      end
      m[i] = s && pres[i];
    end
    return m;
  endfunction

  task automatic send(input string tag, input logic [31:0] d, input logic lg,
                      input logic [1:0] sh, input int snd, input logic lp);
    logic [N-1:0] m;
    logic found;
    logic [IW-1:0] first;
    @(negedge clk);
    m = model(d, lg, sh, snd);
    found = 1'b0;
    first = '0;
    for (int i = 0; i < N; i++)
      if (m[i] && !found) begin
        found = 1'b1;
        first = IW'(i);
      end
    req_valid = 1'b1; req_dest = d; req_logical = lg;
    req_shorthand = sh; req_sender = IW'(snd); req_lowpri = lp;
    q_mask.push_back(m);
    q_pv.push_back(lp && found);
    q_idx.push_back(first);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: pop expected items as results appear
  always @(negedge clk) begin
    #1;
    if (monitor_on && res_valid) begin
      if (q_mask.size() == 0) begin
        tests++; fails++;
        $display("FAIL R2 unexpected res_valid actual=1 expected=0");
      end else begin
        logic [N-1:0] em;
        logic ep;
        logic [IW-1:0] ei;
        string t;
        em = q_mask.pop_front(); ep = q_pv.pop_front();
        ei = q_idx.pop_front();  t = q_tag.pop_front();
        check(t, 32'(res_mask), 32'(em), "mask");
        check(t, 32'(res_pick_valid), 32'(ep), "pick_valid");
        if (ep) check(t, 32'(res_pick_idx), 32'(ei), "pick_idx");
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      pres[i] = 1'b1;
      ext[i]  = (i >= 4);
      clm[i]  = (i == 2 || i == 3);
    end
    pid[0] = 32'hABCD_0010; pid[1] = 32'hABCD_0011;
    pid[2] = 32'hABCD_0012; pid[3] = 32'hABCD_0013;
    pid[4] = 32'h0000_0012; pid[5] = 32'h0001_0005;
    pid[6] = 32'h0002_0006; pid[7] = 32'h0003_0007;
    lid[0] = 32'h0000_0001; lid[1] = 32'h0000_0002;
    lid[2] = 32'h0000_0031; lid[3] = 32'h0000_0052;
    lid[4] = 32'h0003_0001; lid[5] = 32'h0003_0002;
    lid[6] = 32'h0005_0004; lid[7] = 32'h0005_0008;

    repeat (3) @(negedge clk);
    #1;
    check("R1", 32'(res_valid), 0, "valid in reset");
    check("R1", 32'(res_mask), 0, "mask in reset");
    check("R1", 32'(res_pick_valid), 0, "pick in reset");
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1", 32'(res_valid), 0, "valid after reset");
    monitor_on = 1;

    // back-to-back requests (R2) covering matching rules
    send("R3 full id ext vs low byte", 32'h0000_0012, 0, 2'd0, 0, 0);
    send("R3 upper bits only non-ext", 32'hABCD_0012, 0, 2'd0, 0, 0);
    send("R3 ext exact", 32'h0001_0005, 0, 2'd0, 0, 0);
    send("R4 narrow broadcast", 32'h0000_00FF, 0, 2'd0, 0, 0);
    send("R4 not narrow 0x1FF", 32'h0000_01FF, 0, 2'd0, 0, 0);
    send("R5 wide physical broadcast", 32'hFFFF_FFFF, 0, 2'd0, 0, 0);
    idle(2);
    send("R6 wide logical broadcast", 32'hFFFF_FFFF, 1, 2'd0, 0, 0);
    send("R7 ext logical cluster 3", 32'h0003_0002, 1, 2'd0, 0, 0);
    send("R7 ext logical group mismatch", 32'h0004_0002, 1, 2'd0, 0, 1);
    send("R7 ext logical two agents", 32'h0005_000C, 1, 2'd0, 0, 1);
    send("R8 flat", 32'h0000_0003, 1, 2'd0, 0, 0);
    send("R9 cluster match", 32'h0000_0031, 1, 2'd0, 0, 0);
    send("R9 cluster all groups", 32'h0000_00F3, 1, 2'd0, 0, 0);
    send("R9 cluster nibble no overlap", 32'h0000_0054, 1, 2'd0, 0, 0);
    idle(1);
    send("R10 self", 32'hFFFF_FFFF, 0, 2'd1, 5, 0);
    send("R10 all", 32'h0000_0000, 1, 2'd2, 5, 0);
    send("R10 others", 32'h0000_0012, 0, 2'd3, 0, 1);
    idle(1);
    send("R12 lowpri phys", 32'h0000_0012, 0, 2'd0, 0, 1);
    send("R12 lowpri empty", 32'h0000_0099, 0, 2'd0, 0, 1);
    send("R12 lowpri logical", 32'hFFFF_FFFF, 1, 2'd0, 0, 1);
    idle(1);
    pres[0] = 1'b0; pres[6] = 1'b0;
    send("R11 absent under all", 32'h0, 0, 2'd2, 3, 1);
    send("R11 absent under wide bcast", 32'hFFFF_FFFF, 0, 2'd0, 3, 1);
    send("R11 absent self", 32'h0, 0, 2'd1, 6, 1);
    send("R11 absent flat match", 32'h0000_0001, 1, 2'd0, 0, 1);
    idle(3);
    check("R2", 32'(q_mask.size()), 0, "results outstanding");
    check("R2", 32'(res_valid), 0, "valid idle");
    finish_run();
  end
endmodule